// File: doc/BRIEF.md
# Board interrupt source aggregator

This block gathers interrupt requests from five sources on a mixed-signal I/O board: two input converters, two output converters and the digital I/O unit. Each converter request arrives as a single-cycle pulse and is held in its own sticky flag. The digital I/O source is a level that follows the pending state of the digital I/O controller. All five are packed into an identification byte and ORed onto one registered interrupt line to the host.

The host reaches the identification byte through a byte register address that it shares with a status register. Bit 5 of the byte last written to address 0x0F is a view-select bit. While it is set, reads of 0x0F return the identification byte. While it is clear, the same reads return a status byte that the surrounding wrapper supplies. The host acknowledges each converter source by reading that source's own clear address. The digital I/O bit is never cleared by a read here; it drops only when the controller's pending level drops.

Top module: `board_irq_agg`

## Requirements
- R1: When reset is released, all four converter flags, the view-select bit, the read-data register and the host interrupt output are zero.
- R2: A one-cycle high on a bit of `conv_req` sets that source's flag at the same clock edge. The flag stays set until its clear address is read. Bit 0 is input converter 1, bit 1 is input converter 2, bit 2 is output converter 1 and bit 3 is output converter 2.
- R3: A read strobe at address 0x1 clears the input converter 1 flag, 0x5 clears the input converter 2 flag, 0x9 clears the output converter 1 flag and 0xD clears the output converter 2 flag. Each clear leaves the other flags unchanged. A read of any address other than 0xF returns 0x00.
- R4: When a request pulse and a clear read for the same source fall in the same cycle, the flag ends up set.
- R5: A write strobe to address 0xF loads bit 5 of `wr_data` into the view-select bit. Writes to other addresses leave it unchanged.
- R6: While the view-select bit is set, a read of 0xF returns the identification byte. Bit 0 is input converter 1, bit 1 is input converter 2, bit 2 is output converter 1, bit 3 is digital I/O and bit 4 is output converter 2. Bits 7:5 read as zero.
- R7: While the view-select bit is clear, a read of 0xF returns `alt_status` as it was at the read edge.
- R8: Identification bit 3 equals `dio_pending` delayed by one clock. No read or write changes it.
- R9: `host_irq` is the OR of the five identification bits, registered, so it lags the flags by one clock.
- R10: `rd_data` is loaded only on a cycle with `rd_en` high, at the next clock edge, and it holds its value on all other cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Register read strobe, one cycle per access |
| wr_en | input | 1 | Register write strobe, one cycle per access |
| addr | input | 4 | Byte register offset |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Registered read data |
| conv_req | input | 4 | Converter request pulses (in1, in2, out1, out2) |
| dio_pending | input | 1 | Pending level from the digital I/O controller |
| alt_status | input | 8 | Status byte returned at 0xF when the view-select bit is clear |
| host_irq | output | 1 | Combined interrupt request to the host |

## Verification
A stimulus table drives single sources one at a time. Because exactly one identification bit lights per vector, the runs show that each request lands on its own bit position. Mixed patterns, such as all sources together, alternating pairs and digital I/O combined with converters, show that the flags are independent and that the OR reaches `host_irq`. Directed cases clear a single flag out of a full set to show the clear addresses are selective, and they collide a request with its own clear. They also read all clear addresses while the digital I/O level is high. Finally they toggle the view-select bit with every other data bit set, to show that only bit 5 chooses the view.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int NUM_CONV   = 4;
  localparam int ADDR_BITS  = 4;
  localparam int BYTE_BITS  = 8;
  localparam int ID_USED    = 5;
  localparam int VIEW_BIT   = 5;
  localparam int DIO_IDPOS  = 3;
  localparam logic [ADDR_BITS-1:0] SHARED_ADDR = 4'hF;

  // acknowledge address of each converter source
  function automatic logic [ADDR_BITS-1:0] ack_addr(input int src);
    case (src)
      0:       ack_addr = 4'h1;
      1:       ack_addr = 4'h5;
      2:       ack_addr = 4'h9;
      default: ack_addr = 4'hD;
    endcase
  endfunction

  // identification byte position of each converter source
  function automatic int id_pos(input int src);
    case (src)
      0:       id_pos = 0;
      1:       id_pos = 1;
      2:       id_pos = 2;
      default: id_pos = 4;
    endcase
  endfunction
endpackage

// File: rtl/irqagg_flag.sv
module irqagg_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // set has priority over clear
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/irqagg_readport.sv
module irqagg_readport #(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter logic [AW-1:0] SEL_ADDR = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic          view_id,
  input  logic [DW-1:0] id_byte,
  input  logic [DW-1:0] alt_byte,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] sel_byte;

  always_comb begin
    sel_byte = '0;
    if (addr == SEL_ADDR) sel_byte = view_id ? id_byte : alt_byte;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= sel_byte;
  end
endmodule

// File: rtl/board_irq_agg.sv
module board_irq_agg
  import irqagg_pkg::*;
#(
  parameter int AW = ADDR_BITS,
  parameter int DW = BYTE_BITS,
  parameter int NC = NUM_CONV
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic [NC-1:0] conv_req,
  input  logic          dio_pending,
  input  logic [DW-1:0] alt_status,
  output logic          host_irq
);
  logic [NC-1:0] flag;
  logic [NC-1:0] ack_hit;
  logic          dio_q;
  logic          view_q;
  logic [DW-1:0] id_byte;

  for (genvar s = 0; s < NC; s++) begin : g_src
    assign ack_hit[s] = rd_en && (addr == AW'(ack_addr(s)));
    irqagg_flag u_flag (
      .clk   (clk),
      .rst   (rst),
      .set_i (conv_req[s]),
      .clr_i (ack_hit[s]),
      .flag_o(flag[s])
    );
  end

  always_comb begin
    id_byte = '0;
    for (int s = 0; s < NC; s++) id_byte[id_pos(s)] = flag[s];
    id_byte[DIO_IDPOS] = dio_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dio_q    <= 1'b0;
      view_q   <= 1'b0;
      host_irq <= 1'b0;
    end else begin
      dio_q    <= dio_pending;
      host_irq <= |id_byte[ID_USED-1:0];
      if (wr_en && addr == AW'(SHARED_ADDR)) view_q <= wr_data[VIEW_BIT];
    end
  end

  irqagg_readport #(.AW(AW), .DW(DW), .SEL_ADDR(AW'(SHARED_ADDR))) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .addr    (addr),
    .view_id (view_q),
    .id_byte (id_byte),
    .alt_byte(alt_status),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/board_irq_agg_chk.sv
module board_irq_agg_chk
  import irqagg_pkg::*;
#(
  parameter int AW = ADDR_BITS,
  parameter int DW = BYTE_BITS,
  parameter int NC = NUM_CONV
) (
  input logic          clk,
  input logic          rst,
  input logic          rd_en,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] rd_data,
  input logic [NC-1:0] conv_req,
  input logic          dio_pending,
  input logic          host_irq,
  input logic [NC-1:0] flag,
  input logic          dio_q,
  input logic          view_q
);
  for (genvar s = 0; s < NC; s++) begin : g_a
    p_req_sets_r2: assert property (@(posedge clk) disable iff (rst)
      conv_req[s] |=> flag[s]);
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
      flag[s] && !(rd_en && addr == AW'(ack_addr(s))) |=> flag[s]);
    p_ack_clears_r3: assert property (@(posedge clk) disable iff (rst)
      rd_en && addr == AW'(ack_addr(s)) && !conv_req[s] |=> !flag[s]);
  end

  p_dio_follow_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> dio_q == $past(dio_pending));
  p_irq_or_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> host_irq == $past((|flag) || dio_q));
  p_top_zero_r6: assert property (@(posedge clk) disable iff (rst)
    rd_en && addr == AW'(SHARED_ADDR) && view_q |=> rd_data[DW-1:ID_USED] == '0);
  p_other_zero_r3: assert property (@(posedge clk) disable iff (rst)
    rd_en && addr != AW'(SHARED_ADDR) |=> rd_data == '0);
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
  p_view_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == AW'(SHARED_ADDR)) |=> $stable(view_q));
endmodule

bind board_irq_agg board_irq_agg_chk #(.AW(AW), .DW(DW), .NC(NC)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
  .rd_data(rd_data), .conv_req(conv_req), .dio_pending(dio_pending),
  .host_irq(host_irq), .flag(flag), .dio_q(dio_q), .view_q(view_q)
);

// File: tb/sim_board_irq_agg.sv
module sim_board_irq_agg;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {dio, conv_req[3:0], expected id byte}
  localparam logic [12:0] VEC [NVEC] = '{
    {1'b0, 4'b0001, 8'h01}, {1'b0, 4'b0010, 8'h02},
    {1'b0, 4'b0100, 8'h04}, {1'b0, 4'b1000, 8'h10},
    {1'b1, 4'b0000, 8'h08}, {1'b1, 4'b1111, 8'h1F},
    {1'b0, 4'b1010, 8'h12}, {1'b1, 4'b0101, 8'h0D}};

  logic clk = 0, rst = 1, rd_en = 0, wr_en = 0, dio = 0;
  logic [3:0] addr = 0, req = 0;
  logic [7:0] wdata = 0, alt = 0, rdata;
  logic irq;
  int errors = 0, checks = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  board_irq_agg u0 (.clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wr_data(wdata), .rd_data(rdata), .conv_req(req),
    .dio_pending(dio), .alt_status(alt), .host_irq(irq));

  task automatic check(input string req_tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; v = rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse(input logic [3:0] r);
    @(negedge clk); req = r;
    @(negedge clk); req = 0;
  endtask

  task automatic ack_all();
    logic [7:0] v;
    rd(4'h1, v); rd(4'h5, v); rd(4'h9, v); rd(4'hD, v);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 rd_data", rdata, 8'h00);
    check("R1 host_irq", {7'b0, irq}, 8'h00);
    alt = 8'h3C;
    rd(4'hF, v);
    check("R1 view reset -> R7 alt", v, 8'h3C);

    for (int i = 0; i < NVEC; i++) begin
      wr(4'hF, 8'h20);
      dio = VEC[i][12];
      pulse(VEC[i][11:8]);
      rd(4'hF, v);
      check("R6 id byte", v, VEC[i][7:0]);
      check("R9 irq set", {7'b0, irq}, {7'b0, VEC[i][7:0] != 0});
      dio = 0;
      ack_all();
      rd(4'hF, v);
      check("R3 all acked", v, 8'h00);
      check("R9 irq clear", {7'b0, irq}, 8'h00);
    end

    // R3 selective clear and zero return at ack address
    pulse(4'b1111);
    rd(4'h5, v);
    check("R3 ack read value", v, 8'h00);
    rd(4'hF, v);
    check("R3 selective", v, 8'h15);
    rd(4'h9, v);
    rd(4'hF, v);
    check("R3 selective 2", v, 8'h11);
    ack_all();

    // R4 set beats clear
    @(negedge clk); req = 4'b0001; rd_en = 1; addr = 4'h1;
    @(negedge clk); req = 0; rd_en = 0;
    rd(4'hF, v);
    check("R4 set wins", v, 8'h01);
    ack_all();

    // R8 dio not cleared by reads
    dio = 1;
    ack_all();
    rd(4'hF, v);
    check("R8 dio held", v, 8'h08);
    dio = 0;
    @(negedge clk);
    rd(4'hF, v);
    check("R8 dio drop", v, 8'h00);

    // R10 hold between reads
    alt = 8'hA5;
    pulse(4'b0010);
    rd(4'hF, v);
    repeat (3) @(negedge clk);
    check("R10 hold", rdata, 8'h02);

    // R5 / R7 only bit 5 selects view
    wr(4'hF, 8'hDF);
    rd(4'hF, v);
    check("R7 alt view", v, 8'hA5);
    wr(4'h3, 8'h20);
    rd(4'hF, v);
    check("R5 other addr write", v, 8'hA5);
    wr(4'hF, 8'h20);
    rd(4'hF, v);
    check("R5 view on", v, 8'h02);
    rd(4'h3, v);
    check("R3 other addr zero", v, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule